// File: doc/BRIEF.md
# Eight-Connected Region Labeler

This block scans a binary edge map held in an on-chip pixel memory, one pixel at a time in raster order. It groups foreground pixels into regions. Two pixels belong to the same region when they touch horizontally, vertically or diagonally. A strip of previous-row labels and a union table of provisional labels do the labelling; the block never writes a label image. While the scan runs, each provisional label collects its topmost row, its bottom row and the sum of the column positions of its pixels. A short second pass then follows every provisional label to its root, numbers the roots consecutively and folds the collected features into one entry per final region.

A single start pulse launches a run. The block drives the pixel address and reads one bit back per pixel. When the per-region table is final, it raises done for one cycle. The region count and the feature table, which is read by index, stay valid until the next run. Later stages can rank the regions by vertical length, for example to pick the two longest near-vertical edge traces. The default geometry is 320 columns by 240 rows with room for 255 provisional labels.

Top module: `ccl_labeler`

## Requirements
- R1: Foreground pixels that touch in any of the eight neighbour directions, including both diagonals, end up in one region, however the scan order first splits them.
- R2: When no overflow occurs, region_count equals the number of eight-connected foreground regions in the map.
- R3: At most MAX_LBL provisional labels exist. A foreground pixel opens a new provisional label only when none of its west, north-west, north and north-east neighbours is foreground. If such a pixel arrives with the table full, it gets no label and the overflow flag goes high. The flag stays high until the next accepted start. For a map of isolated pixels, this makes region_count equal MAX_LBL, and the table describes the first MAX_LBL pixels in raster order.
- R4: Each feature entry gives the region's top row and bottom row, with row 0 the first row scanned, and a length equal to bottom minus top plus one.
- R5: Each feature entry gives the sum of the column numbers of all pixels in the region, with column 0 on the left.
- R6: Final labels run from 1 to region_count without gaps, and label 0 stands for background. Feature index k describes the region whose first pixel in raster order comes k-th among all regions.
- R7: After reset, done, overflow and region_count read 0. At the end of a run, done is high for exactly one cycle, and from then on the count and the table hold until the next start.
- R8: A start pulse that arrives while a run is in progress has no effect: the run ends in the same cycle it would have without the pulse, with a single done pulse.
- R9: A map with no foreground pixels gives region_count 0 and overflow 0.
- R10: The pixel at column c and row r is read at address r*COLS+c. Its bit is sampled on pix_data in the cycle after the address is driven, and 1 means foreground.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when the block is idle |
| pix_addr | output | AW | Pixel memory address, row*COLS+col |
| pix_data | input | 1 | Pixel bit read one cycle after the address |
| feat_idx | input | LW | Final label whose features are shown |
| feat_top | output | RW | Top row of the selected region |
| feat_bot | output | RW | Bottom row of the selected region |
| feat_len | output | LENW | Vertical length of the selected region |
| feat_sum | output | SW | Sum of column numbers of the selected region |
| region_count | output | LW | Number of final regions |
| overflow | output | 1 | Sticky flag: the provisional label table was full |
| done | output | 1 | One-cycle pulse when the table is final |

## Verification
The labeler is tried on a reduced 16 by 12 map and compared against a flood-fill model in the bench. Hand-built maps each target one part of the behaviour:
- an empty map and a full map check the two extremes;
- a lone off-centre pixel checks the address order;
- an anti-diagonal stair and a V shape need the north-east merge;
- a comb of bars joined only at the bottom builds long root chains;
- a grid of isolated pixels runs the label table past its capacity.

About thirty random maps of varying density then check that the counts, the region ordering and the features agree with the model. A repeated run with start pulses injected mid-scan must finish with the same latency as a run without them.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_PIX,
    ST_FIND,
    ST_COMMIT,
    ST_RES
  } ccl_state_e;

  // vertical extent of a region from its first and last row
  function automatic int span_len(int top, int bot);
    return bot - top + 1;
  endfunction

endpackage

// File: rtl/ccl_line_buf.sv
module ccl_line_buf #(
  parameter int COLS = 320,
  parameter int LW   = 8,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic [CW-1:0] rd_col,
  output logic [LW-1:0] n_lbl,
  output logic [LW-1:0] ne_lbl,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_col,
  input  logic [LW-1:0] wr_lbl
);

  logic [LW-1:0] mem [COLS];
  logic [CW-1:0] ne_col;

  assign ne_col = rd_col + CW'(1);
  assign n_lbl  = mem[rd_col];
  assign ne_lbl = (int'(rd_col) < COLS - 1) ? mem[ne_col] : '0;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_col] <= wr_lbl;
  end

endmodule

// File: rtl/ccl_parent_tab.sv
module ccl_parent_tab #(
  parameter int MAX_LBL = 255,
  parameter int LW      = 8
) (
  input  logic          clk,
  input  logic [LW-1:0] a_idx,
  output logic [LW-1:0] a_val,
  input  logic [LW-1:0] b_idx,
  output logic [LW-1:0] b_val,
  input  logic          we,
  input  logic [LW-1:0] w_idx,
  input  logic [LW-1:0] w_val
);

  logic [LW-1:0] mem [MAX_LBL+1];

  assign a_val = mem[a_idx];
  assign b_val = mem[b_idx];

  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_val;
  end

endmodule

// File: rtl/ccl_feat_tab.sv
module ccl_feat_tab #(
  parameter int MAX_LBL = 255,
  parameter int LW      = 8,
  parameter int FW      = 41
) (
  input  logic          clk,
  input  logic [LW-1:0] a_idx,
  output logic [FW-1:0] a_val,
  input  logic [LW-1:0] b_idx,
  output logic [FW-1:0] b_val,
  input  logic [LW-1:0] x_idx,
  output logic [FW-1:0] x_val,
  input  logic          we,
  input  logic [LW-1:0] w_idx,
  input  logic [FW-1:0] w_val
);

  logic [FW-1:0] mem [MAX_LBL+1];

  assign a_val = mem[a_idx];
  assign b_val = mem[b_idx];
  assign x_val = mem[x_idx];

  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_val;
  end

endmodule

// File: rtl/ccl_labeler.sv
module ccl_labeler
  import ccl_pkg::*;
#(
  parameter int COLS    = 320,
  parameter int ROWS    = 240,
  parameter int MAX_LBL = 255,
  localparam int CW   = $clog2(COLS),
  localparam int RW   = $clog2(ROWS),
  localparam int LW   = $clog2(MAX_LBL + 1),
  localparam int NW   = $clog2(MAX_LBL + 2),
  localparam int AW   = $clog2(COLS * ROWS),
  localparam int SW   = $clog2((COLS - 1) * COLS * ROWS + 1),
  localparam int LENW = $clog2(ROWS + 1),
  localparam int FW   = 2 * RW + SW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic [AW-1:0]   pix_addr,
  input  logic            pix_data,
  input  logic [LW-1:0]   feat_idx,
  output logic [RW-1:0]   feat_top,
  output logic [RW-1:0]   feat_bot,
  output logic [LENW-1:0] feat_len,
  output logic [SW-1:0]   feat_sum,
  output logic [LW-1:0]   region_count,
  output logic            overflow,
  output logic            done
);

  // feature record layout: {top row, bottom row, column sum}
  function automatic logic [RW-1:0] f_top(logic [FW-1:0] f);
    return f[FW-1 -: RW];
  endfunction
  function automatic logic [RW-1:0] f_bot(logic [FW-1:0] f);
    return f[SW +: RW];
  endfunction
  function automatic logic [SW-1:0] f_sum(logic [FW-1:0] f);
    return f[SW-1:0];
  endfunction
  function automatic logic [FW-1:0] f_new(logic [RW-1:0] r);
    return {r, r, SW'(0)};
  endfunction
  function automatic logic [FW-1:0] f_add_px(logic [FW-1:0] f, logic [RW-1:0] r,
                                             logic [CW-1:0] c);
    return {f_top(f), r, f_sum(f) + SW'(c)};
  endfunction
  function automatic logic [FW-1:0] f_merge(logic [FW-1:0] p, logic [FW-1:0] q);
    logic [RW-1:0] t, b;
    t = (f_top(p) < f_top(q)) ? f_top(p) : f_top(q);
    b = (f_bot(p) > f_bot(q)) ? f_bot(p) : f_bot(q);
    return {t, b, f_sum(p) + f_sum(q)};
  endfunction

  ccl_state_e    st;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [AW-1:0] addr;
  logic [LW-1:0] w_r, nw_r, cur, ra, rb, cnt;
  logic [NW-1:0] nxt, ridx;
  logic          ovf, done_r;

  // named internal events (observed by the bound checker)
  logic          busy, lbl_alloc, link_evt, res_wr, res_root;
  logic [LW-1:0] link_child, link_root, res_final;

  logic [LW-1:0] lb_n, lb_ne;
  logic [LW-1:0] n_v, ne_v, w_v, nw_v, cand_a, cand_b;
  logic [LW-1:0] pa_idx, pa_val, pb_idx, pb_val;
  logic          par_we;
  logic [LW-1:0] par_widx, par_wval;
  logic [LW-1:0] fa_idx, fb_idx;
  logic [FW-1:0] fa_val, fb_val, fx_val;
  logic          ft_we;
  logic [LW-1:0] ft_widx;
  logic [FW-1:0] ft_wval;
  logic          last_px, tbl_full, fa_root, fb_root, find_done;

  ccl_line_buf #(.COLS(COLS), .LW(LW), .CW(CW)) u_line (
    .clk(clk), .rd_col(col), .n_lbl(lb_n), .ne_lbl(lb_ne),
    .wr_en(st == ST_COMMIT), .wr_col(col), .wr_lbl(cur)
  );

  ccl_parent_tab #(.MAX_LBL(MAX_LBL), .LW(LW)) u_par (
    .clk(clk), .a_idx(pa_idx), .a_val(pa_val), .b_idx(pb_idx), .b_val(pb_val),
    .we(par_we), .w_idx(par_widx), .w_val(par_wval)
  );

  ccl_feat_tab #(.MAX_LBL(MAX_LBL), .LW(LW), .FW(FW)) u_feat (
    .clk(clk), .a_idx(fa_idx), .a_val(fa_val), .b_idx(fb_idx), .b_val(fb_val),
    .x_idx(feat_idx), .x_val(fx_val),
    .we(ft_we), .w_idx(ft_widx), .w_val(ft_wval)
  );

  // neighbour labels, masked at the map border
  assign n_v    = (row != '0) ? lb_n : '0;
  assign ne_v   = (row != '0) ? lb_ne : '0;
  assign w_v    = (col != '0) ? w_r : '0;
  assign nw_v   = (col != '0 && row != '0) ? nw_r : '0;
  // north joins both upper corners already, west joins north-west already
  assign cand_a = (n_v != '0) ? n_v : ((w_v != '0) ? w_v : nw_v);
  assign cand_b = (n_v != '0) ? '0 : ne_v;

  assign last_px  = (int'(col) == COLS - 1) && (int'(row) == ROWS - 1);
  assign tbl_full = int'(nxt) > MAX_LBL;
  assign busy     = (st != ST_IDLE);

  assign pa_idx    = (st == ST_RES) ? ridx[LW-1:0] : ra;
  assign pb_idx    = (st == ST_RES) ? pa_val : rb;
  assign fa_root   = (pa_val == ra);
  assign fb_root   = (pb_val == rb);
  assign find_done = (st == ST_FIND) && fa_root && fb_root;
  assign link_evt  = find_done && (ra != rb);
  assign link_child = (ra > rb) ? ra : rb;
  assign link_root  = (ra > rb) ? rb : ra;

  assign lbl_alloc = (st == ST_PIX) && pix_data && (cand_a == '0) && (cand_b == '0)
                     && !tbl_full;

  assign res_wr    = (st == ST_RES) && (ridx != nxt);
  assign res_root  = (pa_val == ridx[LW-1:0]);
  assign res_final = res_root ? cnt + LW'(1) : pb_val;

  assign fa_idx = (st == ST_RES) ? ridx[LW-1:0] : cur;
  assign fb_idx = res_final;

  always_comb begin
    par_we   = 1'b0;
    par_widx = '0;
    par_wval = '0;
    ft_we    = 1'b0;
    ft_widx  = '0;
    ft_wval  = '0;
    if (lbl_alloc) begin
      par_we   = 1'b1;
      par_widx = nxt[LW-1:0];
      par_wval = nxt[LW-1:0];
      ft_we    = 1'b1;
      ft_widx  = nxt[LW-1:0];
      ft_wval  = f_new(row);
    end else if (link_evt) begin
      par_we   = 1'b1;
      par_widx = link_child;
      par_wval = link_root;
    end else if (st == ST_COMMIT && cur != '0) begin
      ft_we    = 1'b1;
      ft_widx  = cur;
      ft_wval  = f_add_px(fa_val, row, col);
    end else if (res_wr) begin
      par_we   = 1'b1;
      par_widx = ridx[LW-1:0];
      par_wval = res_final;
      ft_we    = 1'b1;
      ft_widx  = res_final;
      ft_wval  = res_root ? fa_val : f_merge(fb_val, fa_val);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      col    <= '0;
      row    <= '0;
      addr   <= '0;
      w_r    <= '0;
      nw_r   <= '0;
      cur    <= '0;
      ra     <= '0;
      rb     <= '0;
      cnt    <= '0;
      nxt    <= NW'(1);
      ridx   <= '0;
      ovf    <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          col  <= '0;
          row  <= '0;
          addr <= '0;
          nxt  <= NW'(1);
          ovf  <= 1'b0;
          cnt  <= '0;
          st   <= ST_RD;
        end
        ST_RD: st <= ST_PIX;
        ST_PIX: begin
          if (!pix_data) begin
            cur <= '0;
            st  <= ST_COMMIT;
          end else if (cand_a == '0 && cand_b == '0) begin
            if (!tbl_full) begin
              cur <= nxt[LW-1:0];
              nxt <= nxt + NW'(1);
            end else begin
              cur <= '0;
              ovf <= 1'b1;
            end
            st <= ST_COMMIT;
          end else if (cand_a == '0 || cand_b == '0 || cand_a == cand_b) begin
            cur <= (cand_a != '0) ? cand_a : cand_b;
            st  <= ST_COMMIT;
          end else begin
            ra <= cand_a;
            rb <= cand_b;
            st <= ST_FIND;
          end
        end
        ST_FIND: begin
          if (!fa_root) ra <= pa_val;
          if (!fb_root) rb <= pb_val;
          if (find_done) begin
            cur <= link_root;
            st  <= ST_COMMIT;
          end
        end
        ST_COMMIT: begin
          w_r  <= cur;
          nw_r <= lb_n;
          addr <= addr + AW'(1);
          if (int'(col) == COLS - 1) begin
            col <= '0;
            row <= row + RW'(1);
          end else begin
            col <= col + CW'(1);
          end
          if (last_px) begin
            ridx <= NW'(1);
            st   <= ST_RES;
          end else begin
            st <= ST_RD;
          end
        end
        ST_RES: begin
          if (!res_wr) begin
            done_r <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            if (res_root) cnt <= cnt + LW'(1);
            ridx <= ridx + NW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pix_addr     = addr;
  assign feat_top     = f_top(fx_val);
  assign feat_bot     = f_bot(fx_val);
  assign feat_sum     = f_sum(fx_val);
  assign feat_len     = LENW'(span_len(int'(f_top(fx_val)), int'(f_bot(fx_val))));
  assign region_count = cnt;
  assign overflow     = ovf;
  assign done         = done_r;

endmodule

module ccl_labeler_chk #(
  parameter int MAX_LBL = 255,
  parameter int LW      = 8,
  parameter int NW      = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          busy,
  input logic          overflow,
  input logic          lbl_alloc,
  input logic [NW-1:0] nxt,
  input logic          link_evt,
  input logic [LW-1:0] link_child,
  input logic [LW-1:0] link_root,
  input logic [LW-1:0] region_count
);

  p_alloc_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_alloc |-> int'(nxt) <= MAX_LBL);

  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(start && !busy)) |=> overflow);

  p_link_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |-> (link_root < link_child) && (link_root != '0));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> int'(region_count) < int'(nxt));

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(region_count));

endmodule

bind ccl_labeler ccl_labeler_chk #(.MAX_LBL(MAX_LBL), .LW(LW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
  .overflow(overflow), .lbl_alloc(lbl_alloc), .nxt(nxt), .link_evt(link_evt),
  .link_child(link_child), .link_root(link_root), .region_count(region_count)
);

// File: tb/test_ccl_labeler.sv
module test_ccl_labeler;
  localparam int COLS    = 16;
  localparam int ROWS    = 12;
  localparam int MAX_LBL = 31;
  localparam int NPIX    = COLS * ROWS;
  localparam int RW      = $clog2(ROWS);
  localparam int LW      = $clog2(MAX_LBL + 1);
  localparam int AW      = $clog2(COLS * ROWS);
  localparam int SW      = $clog2((COLS - 1) * COLS * ROWS + 1);
  localparam int LENW    = $clog2(ROWS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] pix_addr;
  logic pix_data = 1'b0;
  logic [LW-1:0] feat_idx = '0;
  logic [RW-1:0] feat_top, feat_bot;
  logic [LENW-1:0] feat_len;
  logic [SW-1:0] feat_sum;
  logic [LW-1:0] region_count;
  logic overflow, done;

  always #4 clk = ~clk;

  logic img [NPIX];
  always @(posedge clk) pix_data <= (int'(pix_addr) < NPIX) ? img[pix_addr] : 1'b0;

  ccl_labeler #(.COLS(COLS), .ROWS(ROWS), .MAX_LBL(MAX_LBL)) i_ccl_labeler (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_addr(pix_addr), .pix_data(pix_data),
    .feat_idx(feat_idx), .feat_top(feat_top), .feat_bot(feat_bot), .feat_len(feat_len),
    .feat_sum(feat_sum), .region_count(region_count), .overflow(overflow), .done(done)
  );

  int nvec = 0;
  int nerr = 0;

  task automatic check_eq(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model state
  int rl [NPIX];
  int rank [NPIX];
  int ex_top [NPIX+1];
  int ex_bot [NPIX+1];
  int ex_sum [NPIX+1];
  int ncomp, prov;

  function automatic bit fg(int c, int r);
    if (c < 0 || c >= COLS || r < 0 || r >= ROWS) return 1'b0;
    return img[r*COLS + c];
  endfunction

  task automatic ref_model();
    bit changed;
    for (int p = 0; p < NPIX; p++) rl[p] = img[p] ? p + 1 : 0;
    do begin
      changed = 1'b0;
      for (int p = 0; p < NPIX; p++) begin
        if (rl[p] != 0) begin
          for (int dy = -1; dy <= 1; dy++) begin
            for (int dx = -1; dx <= 1; dx++) begin
              int c, r, q;
              c = p % COLS + dx;
              r = p / COLS + dy;
              if (fg(c, r)) begin
                q = r*COLS + c;
                if (rl[q] < rl[p]) begin
                  rl[p] = rl[q];
                  changed = 1'b1;
                end
              end
            end
          end
        end
      end
    end while (changed);
    ncomp = 0;
    prov = 0;
    for (int p = 0; p < NPIX; p++) begin
      int c, r;
      c = p % COLS;
      r = p / COLS;
      if (img[p]) begin
        if (!fg(c-1, r) && !fg(c-1, r-1) && !fg(c, r-1) && !fg(c+1, r-1)) prov++;
        if (rl[p] == p + 1) begin
          ncomp++;
          rank[p] = ncomp;
          ex_top[ncomp] = r;
          ex_bot[ncomp] = r;
          ex_sum[ncomp] = 0;
        end
        begin
          int k;
          k = rank[rl[p] - 1];
          ex_bot[k] = r;
          ex_sum[k] += c;
        end
      end
    end
  endtask

  task automatic run(input bit poke, output int lat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
      if (poke && !done) start = (lat % 5 == 0);
    end
    start = 1'b0;
    check_eq("R7 done seen", int'(done), 1);
    @(negedge clk);
    check_eq("R7 done one cycle", int'(done), 0);
  endtask

  task automatic check_image(input string tag, input bit exact_ovf);
    int lat, n;
    ref_model();
    run(1'b0, lat);
    if (prov <= MAX_LBL) begin
      check_eq({tag, " R3 no overflow"}, int'(overflow), 0);
      check_eq({tag, " R2 count"}, int'(region_count), ncomp);
      n = ncomp;
    end else begin
      check_eq({tag, " R3 overflow set"}, int'(overflow), 1);
      n = 0;
      if (exact_ovf) begin
        check_eq({tag, " R3 capped count"}, int'(region_count), MAX_LBL);
        n = MAX_LBL;
      end
    end
    for (int k = 1; k <= n; k++) begin
      feat_idx = LW'(k);
      #1;
      check_eq({tag, " R4 R6 top"}, int'(feat_top), ex_top[k]);
      check_eq({tag, " R4 R6 bottom"}, int'(feat_bot), ex_bot[k]);
      check_eq({tag, " R4 length"}, int'(feat_len), ex_bot[k] - ex_top[k] + 1);
      check_eq({tag, " R5 column sum"}, int'(feat_sum), ex_sum[k]);
    end
  endtask

  task automatic clear_img();
    for (int p = 0; p < NPIX; p++) img[p] = 1'b0;
  endtask

  task automatic set_px(input int c, input int r);
    img[r*COLS + c] = 1'b1;
  endtask

  task automatic random_img(input int dens);
    for (int p = 0; p < NPIX; p++) img[p] = ($urandom_range(99) < dens);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R7 watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int lat_a, lat_b, extra;
    clear_img();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check_eq("R7 reset done", int'(done), 0);
    check_eq("R7 reset count", int'(region_count), 0);
    check_eq("R7 reset overflow", int'(overflow), 0);

    // R9 empty map
    clear_img();
    check_image("R9 empty", 1'b0);
    check_eq("R9 empty count", int'(region_count), 0);

    // full map: one region
    for (int p = 0; p < NPIX; p++) img[p] = 1'b1;
    check_image("R2 full", 1'b0);

    // R10 lone pixel off centre
    clear_img();
    set_px(13, 9);
    check_image("R10 lone", 1'b0);
    feat_idx = LW'(1);
    #1;
    check_eq("R10 lone row", int'(feat_top), 9);
    check_eq("R10 lone column", int'(feat_sum), 13);

    // R1 anti-diagonal stair
    clear_img();
    for (int k = 0; k < ROWS; k++) set_px(COLS - 2 - k, k);
    check_image("R1 stair", 1'b0);
    check_eq("R1 stair count", int'(region_count), 1);

    // R1 V shape meeting at the bottom
    clear_img();
    for (int k = 0; k < 6; k++) begin
      set_px(2 + k, k);
      set_px(13 - k, k);
    end
    set_px(8, 6);
    check_image("R1 vee", 1'b0);
    check_eq("R1 vee count", int'(region_count), 1);

    // R1 comb of bars joined only at the bottom, plus a separate blob
    clear_img();
    for (int c = 0; c < COLS; c += 2)
      for (int r = 0; r < 9; r++) set_px(c, r);
    for (int c = 0; c < COLS; c++) set_px(c, 9);
    set_px(3, 11);
    set_px(4, 11);
    check_image("R1 comb", 1'b0);
    check_eq("R1 comb count", int'(region_count), 2);

    // R3 isolated grid beyond capacity
    clear_img();
    for (int r = 0; r < ROWS; r += 2)
      for (int c = 0; c < COLS; c += 2) set_px(c, r);
    check_image("R3 grid", 1'b1);

    // R3 flag cleared on next run
    clear_img();
    set_px(0, 0);
    check_image("R3 cleared", 1'b0);
    check_eq("R3 cleared flag", int'(overflow), 0);

    // R8 start pulses during a run change nothing
    random_img(35);
    check_image("R8 base", 1'b0);
    run(1'b0, lat_a);
    run(1'b1, lat_b);
    check_eq("R8 latency", lat_b, lat_a);
    extra = 0;
    repeat (40) begin
      @(negedge clk);
      if (done) extra++;
    end
    check_eq("R8 single done", extra, 0);
    check_eq("R8 count kept", int'(region_count), ncomp);

    // random sweep
    for (int t = 0; t < 30; t++) begin
      random_img(8 + (t % 6) * 8);
      check_image("R2 random", 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule